// File: doc/BRIEF.md
# Operand Access Breakpoint Comparator

This block belongs to a debug break controller. On every CPU operand access it decides whether the access matches a set of programmed conditions. When it does, it raises a break request. Each access arrives with these inputs:

- a 32-bit address
- a two-bit operand size
- a write flag
- the 64-bit data bus
- a flag marking accesses that move no data, such as prefetch and cache-block operations
- a valid strobe

The conditions live in four small configuration registers, each loaded through its own write-enable port:

- a target address
- a reference data word
- a data mask
- a control word holding the size select, the direction select and the data-match enable

The address check ignores a number of low address bits that depends on the operand size. A target of 0x00001003 therefore catches:

- a byte access at 0x1003
- a word access at 0x1002
- a longword access at 0x1000

The data check applies a mask to the reference value. Narrow accesses take their data from the low bits of the bus. A quadword access is split into two 32-bit halves, and the data check passes if either half matches. The result is registered, so each matching access produces a break pulse one cycle long, in the cycle after the access.

Top module: `opbrk_unit`

## Requirements
- R1: A synchronous active-high reset clears the break output and all configuration registers: target address 0, reference data 0, mask 0, size select off, direction "any", data match off.
- R2: Operand size encoding is 0 = byte, 1 = word, 2 = longword, 3 = quadword. The address check compares bits 31:0 for a byte access, bits 31:1 for a word access, bits 31:2 for a longword access and bits 31:3 for a quadword access.
- R3: When the size select is off, the ignored low address bits are chosen from the size of each access. With a target of 0x00001003, a longword access at 0x1000, a word access at 0x1002 and a quadword access at 0x1000 all match, while a word access at 0x1000 and a longword access at 0x1004 do not.
- R4: When the size select is on, only accesses whose size equals the programmed size can match.
- R5: The direction select is encoded 0 = any, 1 = reads only, 2 = writes only, 3 = any. The access write flag is 1 for a write.
- R6: With data match enabled, a break requires both the address condition and the data condition. Byte, word and longword accesses compare bus bits 7:0, 15:0 and 31:0 against the same bits of the reference data.
- R7: A mask bit set to 1 removes that bit from the data comparison. The data condition holds when (bus XOR reference) AND NOT mask is zero over the compared bits.
- R8: For a quadword access with data match enabled, bus bits 31:0 and bus bits 63:32 are each compared with the 32-bit reference and mask. The data condition holds if either half matches.
- R9: An access flagged as carrying no data never matches while data match is enabled. With data match off, such an access is judged on its other conditions only.
- R10: Data match enabled with the size select off never produces a break.
- R11: The break output is high for exactly the one cycle following each valid matching access. Back-to-back matching accesses give back-to-back pulses. Inputs presented without the valid strobe never cause a break.
- R12: A configuration write takes effect from the next cycle. An access in the same cycle as the write is judged against the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_we | input | 1 | Write enable for the target address |
| cfg_addr_wd | input | 32 | New target address |
| cfg_data_we | input | 1 | Write enable for the reference data |
| cfg_data_wd | input | 32 | New reference data |
| cfg_mask_we | input | 1 | Write enable for the data mask |
| cfg_mask_wd | input | 32 | New data mask (1 = bit ignored) |
| cfg_ctrl_we | input | 1 | Write enable for the control word |
| cfg_size_sel_wd | input | 1 | New size select enable |
| cfg_size_wd | input | 2 | New required operand size |
| cfg_dir_wd | input | 2 | New direction select |
| cfg_data_en_wd | input | 1 | New data match enable |
| acc_valid | input | 1 | Operand access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | Access operand size |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_data | input | 64 | Data bus |
| acc_nodata | input | 1 | Access carries no data |
| brk_o | output | 1 | One-cycle break request |

## Verification
On every cycle, the checker enforces a set of filtering rules that must never be violated:

- a break pulse is always preceded by a valid access;
- a size mismatch under size select suppresses the break;
- a direction mismatch suppresses the break;
- a no-data access with data match on suppresses the break;
- data match without size select suppresses the break;
- a byte access at any address other than the target suppresses the break.

The positive side cannot be checked that way and is shown only by the bench's scenarios. It covers:

- that the right accesses do match, including the size-dependent address windows around 0x1003;
- the mask;
- the either-half rule for quadwords;
- the byte lane that narrow accesses use;
- the reset values;
- the timing of configuration writes.

// File: rtl/opbrk_pkg.sv
package opbrk_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_QUAD = 2'd3
   } opsize_e;

   typedef enum logic [1:0] {
      DIR_ANY  = 2'd0,
      DIR_RD   = 2'd1,
      DIR_WR   = 2'd2,
      DIR_ANY3 = 2'd3
   } dirsel_e;

   typedef struct packed {
      logic    size_sel;
      opsize_e size;
      dirsel_e dir;
      logic    data_en;
   } ctrl_t;

endpackage

// File: rtl/opbrk_cfg_regs.sv
module opbrk_cfg_regs
   import opbrk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANE_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_wd,
   input  logic              data_we,
   input  logic [LANE_W-1:0] data_wd,
   input  logic              mask_we,
   input  logic [LANE_W-1:0] mask_wd,
   input  logic              ctrl_we,
   input  ctrl_t             ctrl_wd,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANE_W-1:0] data_q,
   output logic [LANE_W-1:0] mask_q,
   output ctrl_t             ctrl_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         data_q <= '0;
         mask_q <= '0;
         ctrl_q <= '{size_sel: 1'b0, size: SZ_BYTE, dir: DIR_ANY, data_en: 1'b0};
      end else begin
         if (addr_we) addr_q <= addr_wd;
         if (data_we) data_q <= data_wd;
         if (mask_we) mask_q <= mask_wd;
         if (ctrl_we) ctrl_q <= ctrl_wd;
      end
   end

endmodule

// File: rtl/opbrk_addr_cmp.sv
module opbrk_addr_cmp
   import opbrk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] acc_addr,
   input  opsize_e           acc_size,
   input  logic [ADDR_W-1:0] tgt_addr,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] care;

   always_comb begin
      // Drop log2(bytes) low bits for the access width.
      care = ~((ONE << acc_size) - ONE);
      hit  = ((acc_addr ^ tgt_addr) & care) == '0;
   end

endmodule

// File: rtl/opbrk_data_cmp.sv
module opbrk_data_cmp
   import opbrk_pkg::*;
#(
   parameter int LANE_W = 32,
   parameter int NLANES = 2
) (
   input  logic [NLANES*LANE_W-1:0] bus,
   input  opsize_e                  acc_size,
   input  logic [LANE_W-1:0]        ref_data,
   input  logic [LANE_W-1:0]        ref_mask,
   output logic                     hit
);

   logic [LANE_W-1:0] width_care;
   logic [NLANES-1:0] lane_hit;
   logic [NLANES-1:0] lane_use;

   always_comb begin
      if (acc_size == SZ_QUAD) width_care = '1;
      else                     width_care = ~({LANE_W{1'b1}} << (8 << acc_size));
   end

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      logic [LANE_W-1:0] diff;
      logic [LANE_W-1:0] care;
      if (l == 0) begin : g_low
         assign care        = width_care & ~ref_mask;
         assign lane_use[l] = 1'b1;
      end else begin : g_high
         assign care        = ~ref_mask;
         assign lane_use[l] = (acc_size == SZ_QUAD);
      end
      assign diff        = bus[l*LANE_W +: LANE_W] ^ ref_data;
      assign lane_hit[l] = (diff & care) == '0;
   end

   assign hit = |(lane_hit & lane_use);

endmodule

// File: rtl/opbrk_unit.sv
module opbrk_unit
   import opbrk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANE_W = 32,
   parameter int BUS_W  = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_addr_we,
   input  logic [ADDR_W-1:0] cfg_addr_wd,
   input  logic              cfg_data_we,
   input  logic [LANE_W-1:0] cfg_data_wd,
   input  logic              cfg_mask_we,
   input  logic [LANE_W-1:0] cfg_mask_wd,
   input  logic              cfg_ctrl_we,
   input  logic              cfg_size_sel_wd,
   input  logic [1:0]        cfg_size_wd,
   input  logic [1:0]        cfg_dir_wd,
   input  logic              cfg_data_en_wd,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic              acc_write,
   input  logic [BUS_W-1:0]  acc_data,
   input  logic              acc_nodata,
   output logic              brk_o
);

   localparam int NLANES = BUS_W / LANE_W;

   if (NLANES * LANE_W != BUS_W || NLANES != 2) begin : g_bad_bus
      $error("opbrk_unit: BUS_W must be exactly two lanes of LANE_W");
   end
   if (LANE_W < 32) begin : g_bad_lane
      $error("opbrk_unit: LANE_W must cover a longword");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("opbrk_unit: ADDR_W too small for quadword alignment");
   end

   ctrl_t             ctrl_wd;
   ctrl_t             ctrl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANE_W-1:0] data_q;
   logic [LANE_W-1:0] mask_q;
   opsize_e           size_e;
   logic              addr_hit;
   logic              data_hit;
   logic              size_ok;
   logic              dir_ok;
   logic              data_ok;
   logic              match;

   assign ctrl_wd = '{size_sel: cfg_size_sel_wd,
                      size:     opsize_e'(cfg_size_wd),
                      dir:      dirsel_e'(cfg_dir_wd),
                      data_en:  cfg_data_en_wd};
   assign size_e  = opsize_e'(acc_size);

   opbrk_cfg_regs #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .addr_we (cfg_addr_we),
      .addr_wd (cfg_addr_wd),
      .data_we (cfg_data_we),
      .data_wd (cfg_data_wd),
      .mask_we (cfg_mask_we),
      .mask_wd (cfg_mask_wd),
      .ctrl_we (cfg_ctrl_we),
      .ctrl_wd (ctrl_wd),
      .addr_q  (addr_q),
      .data_q  (data_q),
      .mask_q  (mask_q),
      .ctrl_q  (ctrl_q)
   );

   opbrk_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
      .acc_addr (acc_addr),
      .acc_size (size_e),
      .tgt_addr (addr_q),
      .hit      (addr_hit)
   );

   opbrk_data_cmp #(.LANE_W(LANE_W), .NLANES(NLANES)) u_data (
      .bus      (acc_data),
      .acc_size (size_e),
      .ref_data (data_q),
      .ref_mask (mask_q),
      .hit      (data_hit)
   );

   always_comb begin
      size_ok = !ctrl_q.size_sel || (size_e == ctrl_q.size);
      unique case (ctrl_q.dir)
         DIR_RD:  dir_ok = !acc_write;
         DIR_WR:  dir_ok = acc_write;
         default: dir_ok = 1'b1;
      endcase
      data_ok = !ctrl_q.data_en ||
                (ctrl_q.size_sel && !acc_nodata && data_hit);
      match   = addr_hit && size_ok && dir_ok && data_ok;
   end

   always_ff @(posedge clk) begin
      if (rst) brk_o <= 1'b0;
      else     brk_o <= acc_valid && match;
   end

endmodule

// File: rtl/opbrk_chk.sv
module opbrk_chk
   import opbrk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        acc_size,
   input logic              acc_write,
   input logic              acc_nodata,
   input logic [ADDR_W-1:0] addr_q,
   input ctrl_t             ctrl_q,
   input logic              brk_o
);

   p_brk_needs_access_r11: assert property (@(posedge clk) disable iff (rst)
      brk_o |-> $past(acc_valid));

   p_size_filter_r4: assert property (@(posedge clk) disable iff (rst)
      $past(acc_valid && ctrl_q.size_sel && (acc_size != ctrl_q.size)) |-> !brk_o);

   p_dir_filter_r5: assert property (@(posedge clk) disable iff (rst)
      $past(acc_valid && ((ctrl_q.dir == DIR_RD && acc_write) ||
                          (ctrl_q.dir == DIR_WR && !acc_write))) |-> !brk_o);

   p_nodata_r9: assert property (@(posedge clk) disable iff (rst)
      $past(acc_valid && acc_nodata && ctrl_q.data_en) |-> !brk_o);

   p_unsized_data_r10: assert property (@(posedge clk) disable iff (rst)
      $past(acc_valid && ctrl_q.data_en && !ctrl_q.size_sel) |-> !brk_o);

   p_byte_addr_r2: assert property (@(posedge clk) disable iff (rst)
      $past(acc_valid && (acc_size == 2'd0) && (acc_addr != addr_q)) |-> !brk_o);

endmodule

bind opbrk_unit opbrk_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .acc_valid  (acc_valid),
   .acc_addr   (acc_addr),
   .acc_size   (acc_size),
   .acc_write  (acc_write),
   .acc_nodata (acc_nodata),
   .addr_q     (addr_q),
   .ctrl_q     (ctrl_q),
   .brk_o      (brk_o)
);

// File: tb/opbrk_unit_tb.sv
`timescale 1ns/1ps
module opbrk_unit_tb;

   typedef struct packed {
      logic [23:0] tag;
      logic [31:0] c_addr;
      logic [31:0] c_data;
      logic [31:0] c_mask;
      logic        c_ssel;
      logic [1:0]  c_size;
      logic [1:0]  c_dir;
      logic        c_den;
      logic [31:0] a_addr;
      logic [1:0]  a_size;
      logic        a_wr;
      logic [63:0] a_data;
      logic        a_nd;
      logic        exp;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{"R2 ", 32'h1003, 0, 0, 0, 2'd0, 2'd0, 0, 32'h1003, 2'd0, 0, 64'h0, 0, 1},
      '{"R2 ", 32'h1003, 0, 0, 0, 2'd0, 2'd0, 0, 32'h1002, 2'd0, 0, 64'h0, 0, 0},
      '{"R3 ", 32'h1003, 0, 0, 0, 2'd0, 2'd0, 0, 32'h1000, 2'd2, 0, 64'h0, 0, 1},
      '{"R3 ", 32'h1003, 0, 0, 0, 2'd0, 2'd0, 0, 32'h1002, 2'd1, 0, 64'h0, 0, 1},
      '{"R3 ", 32'h1003, 0, 0, 0, 2'd0, 2'd0, 0, 32'h1000, 2'd1, 0, 64'h0, 0, 0},
      '{"R3 ", 32'h1003, 0, 0, 0, 2'd0, 2'd0, 0, 32'h1000, 2'd3, 0, 64'h0, 0, 1},
      '{"R3 ", 32'h1003, 0, 0, 0, 2'd0, 2'd0, 0, 32'h1004, 2'd2, 0, 64'h0, 0, 0},
      '{"R4 ", 32'h1003, 0, 0, 1, 2'd2, 2'd0, 0, 32'h1002, 2'd1, 0, 64'h0, 0, 0},
      '{"R4 ", 32'h1003, 0, 0, 1, 2'd2, 2'd0, 0, 32'h1000, 2'd2, 0, 64'h0, 0, 1},
      '{"R5 ", 32'h0040, 0, 0, 0, 2'd0, 2'd1, 0, 32'h0040, 2'd2, 1, 64'h0, 0, 0},
      '{"R5 ", 32'h0040, 0, 0, 0, 2'd0, 2'd1, 0, 32'h0040, 2'd2, 0, 64'h0, 0, 1},
      '{"R5 ", 32'h0040, 0, 0, 0, 2'd0, 2'd2, 0, 32'h0040, 2'd2, 0, 64'h0, 0, 0},
      '{"R6 ", 32'h3000, 32'hCAFEF00D, 0, 1, 2'd2, 2'd0, 1, 32'h3000, 2'd2, 1, 64'h11111111_CAFEF00D, 0, 1},
      '{"R6 ", 32'h3000, 32'hCAFEF00D, 0, 1, 2'd2, 2'd0, 1, 32'h3008, 2'd2, 1, 64'h11111111_CAFEF00D, 0, 0},
      '{"R6 ", 32'h2001, 32'h000000A5, 0, 1, 2'd0, 2'd0, 1, 32'h2001, 2'd0, 0, 64'hFFFFFFFF_FFFFFFA5, 0, 1},
      '{"R7 ", 32'h3000, 32'h12345600, 32'h000000FF, 1, 2'd2, 2'd0, 1, 32'h3000, 2'd2, 0, 64'h0_123456FF, 0, 1},
      '{"R7 ", 32'h3000, 32'h12345600, 32'h000000FF, 1, 2'd2, 2'd0, 1, 32'h3000, 2'd2, 0, 64'h0_123457FF, 0, 0},
      '{"R8 ", 32'h4000, 32'hDEADBEEF, 0, 1, 2'd3, 2'd0, 1, 32'h4000, 2'd3, 0, 64'hDEADBEEF_00000000, 0, 1},
      '{"R8 ", 32'h4000, 32'hDEADBEEF, 0, 1, 2'd3, 2'd0, 1, 32'h4000, 2'd3, 0, 64'h00000000_DEADBEEF, 0, 1},
      '{"R8 ", 32'h4000, 32'hDEADBEEF, 0, 1, 2'd3, 2'd0, 1, 32'h4000, 2'd3, 0, 64'hDEADBEEE_DEADBEEE, 0, 0},
      '{"R9 ", 32'h3000, 32'hCAFEF00D, 0, 1, 2'd2, 2'd0, 1, 32'h3000, 2'd2, 0, 64'h0_CAFEF00D, 1, 0},
      '{"R9 ", 32'h3000, 32'hCAFEF00D, 0, 1, 2'd2, 2'd0, 0, 32'h3000, 2'd2, 0, 64'h0, 1, 1},
      '{"R10", 32'h3000, 32'hCAFEF00D, 0, 0, 2'd2, 2'd0, 1, 32'h3000, 2'd2, 0, 64'h0_CAFEF00D, 0, 0}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_addr_we, cfg_data_we, cfg_mask_we, cfg_ctrl_we;
   logic [31:0] cfg_addr_wd, cfg_data_wd, cfg_mask_wd;
   logic        cfg_size_sel_wd, cfg_data_en_wd;
   logic [1:0]  cfg_size_wd, cfg_dir_wd;
   logic        acc_valid, acc_write, acc_nodata;
   logic [31:0] acc_addr;
   logic [1:0]  acc_size;
   logic [63:0] acc_data;
   logic        brk_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   opbrk_unit u_dut (.*);

   task automatic check(input logic got, input logic exp, input string tag, input string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: brk_o=%b expected %b", tag, what, got, exp);
      end
   endtask

   task automatic idle_inputs();
      cfg_addr_we = 0; cfg_data_we = 0; cfg_mask_we = 0; cfg_ctrl_we = 0;
      acc_valid = 0; acc_write = 0; acc_nodata = 0;
      acc_addr = '0; acc_size = '0; acc_data = '0;
   endtask

   task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                         input logic [63:0] d, input logic nd);
      acc_valid = 1; acc_addr = a; acc_size = sz; acc_write = wr;
      acc_data = d; acc_nodata = nd;
   endtask

   task automatic run_vec(input vec_t v);
      @(negedge clk);
      cfg_addr_we = 1; cfg_addr_wd = v.c_addr;
      cfg_data_we = 1; cfg_data_wd = v.c_data;
      cfg_mask_we = 1; cfg_mask_wd = v.c_mask;
      cfg_ctrl_we = 1; cfg_size_sel_wd = v.c_ssel; cfg_size_wd = v.c_size;
      cfg_dir_wd = v.c_dir; cfg_data_en_wd = v.c_den;
      @(negedge clk);
      idle_inputs();
      access(v.a_addr, v.a_size, v.a_wr, v.a_data, v.a_nd);
      @(negedge clk);
      check(brk_o, v.exp, string'(v.tag), "vector result");
      idle_inputs();
      @(negedge clk);
      check(brk_o, 1'b0, "R11", "pulse ends after one cycle");
   endtask

   initial begin
      #(20ns * 20000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      cfg_addr_wd = '0; cfg_data_wd = '0; cfg_mask_wd = '0;
      cfg_size_sel_wd = 0; cfg_size_wd = 0; cfg_dir_wd = 0; cfg_data_en_wd = 0;
      rst = 1;
      repeat (3) @(negedge clk);
      check(brk_o, 1'b0, "R1", "output during reset");
      rst = 0;

      // R1: cleared config targets address 0, any size/direction, no data
      access(32'h0, 2'd0, 1, 64'hFFFF, 0);
      @(negedge clk);
      check(brk_o, 1'b1, "R1", "byte at 0 matches reset config");
      access(32'h1, 2'd0, 0, 64'h0, 0);
      @(negedge clk);
      check(brk_o, 1'b0, "R1", "byte at 1 misses reset config");
      idle_inputs();
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R11: back-to-back matches, then matching inputs without valid
      @(negedge clk);
      cfg_addr_we = 1; cfg_addr_wd = 32'h1003;
      cfg_ctrl_we = 1; cfg_size_sel_wd = 0; cfg_size_wd = 0; cfg_dir_wd = 0; cfg_data_en_wd = 0;
      @(negedge clk);
      idle_inputs();
      access(32'h1003, 2'd0, 0, 64'h0, 0);
      @(negedge clk);
      check(brk_o, 1'b1, "R11", "first of back-to-back");
      access(32'h1000, 2'd2, 0, 64'h0, 0);
      @(negedge clk);
      check(brk_o, 1'b1, "R11", "second of back-to-back");
      acc_valid = 0;
      @(negedge clk);
      check(brk_o, 1'b0, "R11", "matching inputs without valid");
      @(negedge clk);
      check(brk_o, 1'b0, "R11", "still idle without valid");

      // R12: access in the write cycle sees the old target
      cfg_addr_we = 1; cfg_addr_wd = 32'h5000;
      access(32'h1003, 2'd0, 0, 64'h0, 0);
      @(negedge clk);
      check(brk_o, 1'b1, "R12", "same-cycle access uses old target");
      cfg_addr_we = 0;
      @(negedge clk);
      check(brk_o, 1'b0, "R12", "old target gone after write");
      access(32'h5000, 2'd0, 0, 64'h0, 0);
      @(negedge clk);
      check(brk_o, 1'b1, "R12", "new target active");
      idle_inputs();
      @(negedge clk);

      // R1: reset mid-run clears a pending break
      access(32'h5000, 2'd0, 0, 64'h0, 0);
      rst = 1;
      @(negedge clk);
      check(brk_o, 1'b0, "R1", "reset overrides match");
      rst = 0;
      @(negedge clk);
      check(brk_o, 1'b0, "R1", "target cleared by reset");
      idle_inputs();
      @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule